// File: doc/BRIEF.md
# Four-Bank Memory Command Decoder and Bank State Tracker

This block sits beside a synchronous multi-bank memory and watches the command pins. Each clock it turns the chip-select, row strobe, column strobe, write-enable, bank-select and A10 inputs into one decoded command. It keeps a state machine for every bank, and it flags any command that the present bank states do not allow. A flagged command leaves every bank state unchanged.

A small mode register holds a 3-bit burst code that is loaded by the mode-set command. The code sets the burst length, a full-page burst, or a serial page mode. In serial page mode an activate puts the bank into a special active state. A serial read or write from that state runs until an all-bank precharge ends it.

The clock-enable input is tracked one cycle delayed. It drives power-down, self refresh and clock suspend. Precharge and refresh recovery times are counted in clocks from parameters. All outputs are registered and show the result of the command sampled at the previous rising edge.

Top module: `bank_cmd_tracker`

## Requirements
- R1: Clock enable sampled high at the previous edge makes the pins decode as follows. CS high is deselect (code 1). With CS low, {RAS,CAS,WE} gives: 111 NOP (0), 000 mode set (2), 001 refresh (3, or self-refresh entry 4 when CKE is low now), 011 activate (5), 101 read (6, or 7 with A10 high), 100 write (8, or 9 with A10 high), 010 precharge (10, or precharge-all 11 with A10 high), 110 burst stop (12). The code appears on cmd_o one cycle after the edge.
- R2: Bank state codes are IDLE 0, ACTIVE 1, READ 2, WRITE 3, READ_AP 4, WRITE_AP 5, PRECH 6, REFR 7, S_ACTIVE 8, S_READ 9, S_WRITE 10, and bank i sits at bank_state_o[4i+3:4i]. Activate is legal only to an IDLE bank and moves it to ACTIVE.
- R3: A read or write sets the bank to READ or WRITE for BL cycles and then to ACTIVE. Burst codes 0, 1, 2 and 3 give BL 1, 2, 4 and 8. Code 7 is a full page that never ends by itself. Code 6 is serial page mode. Codes 4 and 5 give BL 1. The reset code is 2.
- R4: A read or write with A10 high sets READ_AP or WRITE_AP for BL cycles, then PRECH. While a bank is in READ_AP or WRITE_AP, read, write, precharge and burst stop to it are illegal, and so is precharge-all.
- R5: Single precharge moves an ACTIVE, READ or WRITE bank to PRECH and leaves the other banks untouched. It is a legal no-op on an IDLE or PRECH bank. Precharge-all moves every non-idle, non-recovering bank to PRECH. PRECH lasts T_RP cycles and then becomes IDLE, and activate during PRECH is illegal.
- R6: Refresh is legal only when all banks are IDLE. It puts every bank in REFR for T_RC cycles. Mode set is also legal only when all banks are IDLE.
- R7: A read or write to a READ or WRITE bank ends the running burst and starts a new full-length one. Burst stop moves a READ or WRITE bank to ACTIVE and is illegal in any other state.
- R8: In serial page mode, activate gives S_ACTIVE, and a read or write to S_ACTIVE gives S_READ or S_WRITE with no end. Single precharge, activate, burst stop and a further read or write to these banks are illegal. Precharge-all moves them to PRECH.
- R9: An illegal command raises illegal_o for one cycle and changes no bank state or mode register.
- R10: A refresh with CKE falling from all-idle enters self refresh (power_o 2). CKE high sampled while CKE was low leaves self refresh (power_o 0), and every bank is then in REFR for T_RC cycles.
- R11: CKE falling from all-idle with NOP or deselect enters power-down (power_o 1). With any other command it is illegal. While CKE was low at the previous edge, the command pins are ignored and cmd_o shows NOP.
- R12: CKE falling with any bank non-idle executes that cycle's command and then enters clock suspend (power_o 3). Bank states and timers are frozen until CKE high has been sampled.
- R13: After reset, cmd_o is 0, illegal_o is 0, power_o is 0 and every bank is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BANK_W | Bank select |
| a10_i | input | 1 | Auto-precharge / all-bank select bit |
| mode_code_i | input | 3 | Burst code loaded by mode set |
| cmd_o | output | 4 | Decoded command of the previous edge |
| illegal_o | output | 1 | Previous command was illegal |
| power_o | output | 2 | 0 run, 1 power-down, 2 self refresh, 3 clock suspend |
| bank_state_o | output | 4*NUM_BANKS | Per-bank state codes |

## Verification
The block is driven with sequences of legal and illegal commands. Each sequence is aimed at one point:
- Burst length: bursts are run under lengths 1, 4 and 8 and under full page, which shows the burst counter and its end transition.
- Restart and stop: a second read or write is issued mid-burst, and bursts are ended with burst stop. This separates restart from stop.
- Recovery windows: bursts with auto-precharge, single precharge, precharge-all and refresh are each hit with commands inside their windows. This shows the legality table and the T_RP and T_RC counts.
- Power modes: CKE drops are tried from the all-idle state and from a bursting state. This tells power-down, self refresh and clock suspend apart, and shows that pins are ignored while CKE is low.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'd0, CMD_DESEL = 4'd1, CMD_MODE = 4'd2, CMD_REF = 4'd3,
    CMD_SREF = 4'd4, CMD_ACT = 4'd5, CMD_RD = 4'd6, CMD_RDA = 4'd7,
    CMD_WR = 4'd8, CMD_WRA = 4'd9, CMD_PRE = 4'd10, CMD_PREA = 4'd11,
    CMD_BST = 4'd12
  } cmd_e;

  typedef enum logic [3:0] {
    BS_IDLE = 4'd0, BS_ACTIVE = 4'd1, BS_READ = 4'd2, BS_WRITE = 4'd3,
    BS_READ_AP = 4'd4, BS_WRITE_AP = 4'd5, BS_PRECH = 4'd6, BS_REFR = 4'd7,
    BS_SACTIVE = 4'd8, BS_SREAD = 4'd9, BS_SWRITE = 4'd10
  } bank_st_e;

  typedef enum logic [3:0] {
    BA_NONE, BA_ACT, BA_SACT, BA_RD, BA_RDA, BA_WR, BA_WRA,
    BA_SRD, BA_SWR, BA_PRE, BA_BST, BA_REF
  } bank_act_e;

  typedef enum logic [1:0] {
    PW_RUN = 2'd0, PW_PDOWN = 2'd1, PW_SREF = 2'd2, PW_SUSP = 2'd3
  } pwr_e;

  localparam logic [2:0] CODE_SERIAL = 3'd6;
  localparam logic [2:0] CODE_FULL   = 3'd7;
  localparam logic [2:0] CODE_RESET  = 3'd2;
endpackage

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
(
  input  logic cke_q_i,
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic a10_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cke_q_i) begin
      cmd_o = CMD_NOP;
    end else if (cs_n_i) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b111: cmd_o = CMD_NOP;
        3'b000: cmd_o = CMD_MODE;
        3'b001: cmd_o = cke_i ? CMD_REF : CMD_SREF;
        3'b011: cmd_o = CMD_ACT;
        3'b101: cmd_o = a10_i ? CMD_RDA : CMD_RD;
        3'b100: cmd_o = a10_i ? CMD_WRA : CMD_WR;
        3'b010: cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b110: cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/bct_power.sv
module bct_power
  import bct_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  cmd_e cmd_i,
  input  logic all_idle_i,
  output logic cke_q_o,
  output pwr_e pwr_o,
  output logic sref_exit_o,
  output logic fall_bad_o
);
  logic fall;
  assign fall        = cke_q_o & ~cke_i;
  assign sref_exit_o = ~cke_q_o & cke_i & (pwr_o == PW_SREF);
  assign fall_bad_o  = fall & all_idle_i &
                       !(cmd_i inside {CMD_NOP, CMD_DESEL, CMD_SREF});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q_o <= 1'b1;
      pwr_o   <= PW_RUN;
    end else begin
      cke_q_o <= cke_i;
      if (cke_q_o) begin
        if (!cke_i) begin
          if (!all_idle_i)              pwr_o <= PW_SUSP;
          else if (cmd_i == CMD_SREF)   pwr_o <= PW_SREF;
          else                          pwr_o <= PW_PDOWN;
        end else begin
          pwr_o <= PW_RUN;
        end
      end else if (cke_i) begin
        pwr_o <= PW_RUN;
      end
    end
  end
endmodule

// File: rtl/bct_bank.sv
module bct_bank
  import bct_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RC  = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  bank_act_e        act_i,
  input  logic [CNT_W-1:0] burst_len_i,
  input  logic             full_page_i,
  output bank_st_e         state_o
);
  localparam logic [CNT_W-1:0] RP_LD = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] RC_LD = CNT_W'(T_RC);

  logic [CNT_W-1:0] cnt_q;
  logic             last;
  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= BS_IDLE;
      cnt_q   <= '0;
    end else if (act_i != BA_NONE) begin
      unique case (act_i)
        BA_ACT:  state_o <= BS_ACTIVE;
        BA_SACT: state_o <= BS_SACTIVE;
        BA_RD:   begin state_o <= BS_READ;     cnt_q <= burst_len_i; end
        BA_RDA:  begin state_o <= BS_READ_AP;  cnt_q <= burst_len_i; end
        BA_WR:   begin state_o <= BS_WRITE;    cnt_q <= burst_len_i; end
        BA_WRA:  begin state_o <= BS_WRITE_AP; cnt_q <= burst_len_i; end
        BA_SRD:  state_o <= BS_SREAD;
        BA_SWR:  state_o <= BS_SWRITE;
        BA_PRE:  begin state_o <= BS_PRECH; cnt_q <= RP_LD; end
        BA_BST:  state_o <= BS_ACTIVE;
        BA_REF:  begin state_o <= BS_REFR;  cnt_q <= RC_LD; end
        default: state_o <= state_o;
      endcase
    end else if (tick_i) begin
      unique case (state_o)
        BS_READ, BS_WRITE: begin
          if (!full_page_i) begin
            if (last) state_o <= BS_ACTIVE;
            else      cnt_q   <= cnt_q - 1'b1;
          end
        end
        BS_READ_AP, BS_WRITE_AP: begin
          if (!full_page_i) begin
            if (last) begin
              state_o <= BS_PRECH;
              cnt_q   <= RP_LD;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        BS_PRECH, BS_REFR: begin
          if (last) state_o <= BS_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RC      = 6,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_n_i,
  input  logic                   ras_n_i,
  input  logic                   cas_n_i,
  input  logic                   we_n_i,
  input  logic [BANK_W-1:0]      ba_i,
  input  logic                   a10_i,
  input  logic [2:0]             mode_code_i,
  output logic [3:0]             cmd_o,
  output logic                   illegal_o,
  output logic [1:0]             power_o,
  output logic [NUM_BANKS*4-1:0] bank_state_o
);
  localparam int MAX_A = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int MAX_C = (MAX_A > 8) ? MAX_A : 8;
  localparam int CNT_W = $clog2(MAX_C + 1);

  cmd_e             cmd;
  pwr_e             pwr;
  bank_st_e         st [NUM_BANKS];
  bank_act_e        act[NUM_BANKS];
  bank_st_e         tgt;
  logic             cke_q, sref_exit, fall_bad;
  logic             all_idle, ap_busy, ok;
  logic [2:0]       code_q;
  logic [CNT_W-1:0] burst_len;
  logic             full_page, serial;

  bct_decode u_decode (
    .cke_q_i (cke_q),
    .cke_i   (cke_i),
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .a10_i   (a10_i),
    .cmd_o   (cmd)
  );

  bct_power u_power (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .cmd_i       (cmd),
    .all_idle_i  (all_idle),
    .cke_q_o     (cke_q),
    .pwr_o       (pwr),
    .sref_exit_o (sref_exit),
    .fall_bad_o  (fall_bad)
  );

  always_comb begin
    unique case (code_q)
      3'd0:    burst_len = CNT_W'(1);
      3'd1:    burst_len = CNT_W'(2);
      3'd2:    burst_len = CNT_W'(4);
      3'd3:    burst_len = CNT_W'(8);
      default: burst_len = CNT_W'(1);
    endcase
  end
  assign full_page = (code_q == CODE_FULL);
  assign serial    = (code_q == CODE_SERIAL);

  // legality against current bank states
  always_comb begin
    all_idle = 1'b1;
    ap_busy  = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st[i] != BS_IDLE) all_idle = 1'b0;
      if (st[i] inside {BS_READ_AP, BS_WRITE_AP, BS_REFR}) ap_busy = 1'b1;
    end
    tgt = st[ba_i];
    unique case (cmd)
      CMD_NOP, CMD_DESEL:            ok = 1'b1;
      CMD_MODE, CMD_REF, CMD_SREF:   ok = all_idle;
      CMD_ACT:                       ok = (tgt == BS_IDLE);
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
        ok = tgt inside {BS_ACTIVE, BS_READ, BS_WRITE, BS_SACTIVE};
      CMD_PRE:  ok = tgt inside {BS_IDLE, BS_ACTIVE, BS_READ, BS_WRITE, BS_PRECH};
      CMD_PREA: ok = !ap_busy;
      CMD_BST:  ok = tgt inside {BS_READ, BS_WRITE};
      default:  ok = 1'b0;
    endcase
    if (fall_bad) ok = 1'b0;
  end

  // per-bank actions
  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      act[i] = BA_NONE;
      if (sref_exit) begin
        act[i] = BA_REF;
      end else if (ok) begin
        unique case (cmd)
          CMD_ACT:
            if (BANK_W'(i) == ba_i) act[i] = serial ? BA_SACT : BA_ACT;
          CMD_RD:
            if (BANK_W'(i) == ba_i) act[i] = (tgt == BS_SACTIVE) ? BA_SRD : BA_RD;
          CMD_RDA:
            if (BANK_W'(i) == ba_i) act[i] = (tgt == BS_SACTIVE) ? BA_SRD : BA_RDA;
          CMD_WR:
            if (BANK_W'(i) == ba_i) act[i] = (tgt == BS_SACTIVE) ? BA_SWR : BA_WR;
          CMD_WRA:
            if (BANK_W'(i) == ba_i) act[i] = (tgt == BS_SACTIVE) ? BA_SWR : BA_WRA;
          CMD_PRE:
            if (BANK_W'(i) == ba_i && (tgt inside {BS_ACTIVE, BS_READ, BS_WRITE}))
              act[i] = BA_PRE;
          CMD_PREA:
            if (st[i] inside {BS_ACTIVE, BS_READ, BS_WRITE,
                              BS_SACTIVE, BS_SREAD, BS_SWRITE})
              act[i] = BA_PRE;
          CMD_BST:
            if (BANK_W'(i) == ba_i) act[i] = BA_BST;
          CMD_REF:  act[i] = BA_REF;
          default:  act[i] = BA_NONE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bct_bank #(
      .T_RP  (T_RP),
      .T_RC  (T_RC),
      .CNT_W (CNT_W)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (cke_q),
      .act_i       (act[g]),
      .burst_len_i (burst_len),
      .full_page_i (full_page),
      .state_o     (st[g])
    );
    assign bank_state_o[4*g +: 4] = st[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q    <= CODE_RESET;
      cmd_o     <= 4'd0;
      illegal_o <= 1'b0;
    end else begin
      cmd_o     <= cmd;
      illegal_o <= ~ok;
      if (ok && cmd == CMD_MODE) code_q <= mode_code_i;
    end
  end

  assign power_o = pwr;
endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [3:0]             cmd_o,
  input logic                   illegal_o,
  input logic [1:0]             power_o,
  input logic [NUM_BANKS*4-1:0] bank_state_o
);
  a_r10_sref_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_o == 2'd2) |-> (bank_state_o == '0));

  a_r12_suspend_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_o == 2'd3 && $past(power_o) == 2'd3) |-> $stable(bank_state_o));

  a_r9_illegal_real_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cmd_o != 4'd0 && cmd_o != 4'd1));

  a_r6_mode_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'd2 && !illegal_o) |-> (bank_state_o == '0));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    a_r5_prech_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[4*g +: 4] == 4'd6) |=>
        (bank_state_o[4*g +: 4] == 4'd6 || bank_state_o[4*g +: 4] == 4'd0));

    a_r8_serial_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[4*g +: 4] == 4'd9) |=>
        (bank_state_o[4*g +: 4] == 4'd9 || bank_state_o[4*g +: 4] == 4'd6));

    a_r2_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_state_o[4*g +: 4] <= 4'd10);
  end
endmodule

bind bank_cmd_tracker bct_checker #(.NUM_BANKS(NUM_BANKS)) u_bct_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_o        (cmd_o),
  .illegal_o    (illegal_o),
  .power_o      (power_o),
  .bank_state_o (bank_state_o)
);

// File: tb/bank_cmd_tracker_bench.sv
`timescale 1ns/1ps
module bank_cmd_tracker_bench;
  localparam int NB = 4;
  localparam int TRP = 3;
  localparam int TRC = 6;

  localparam int NOP = 0, DESEL = 1, MODE = 2, REF = 3, SREF = 4, ACT = 5,
                 RD = 6, RDA = 7, WR = 8, WRA = 9, PRE = 10, PREA = 11, BST = 12;
  localparam int S_IDLE = 0, S_ACT = 1, S_RD = 2, S_WR = 3, S_RDA = 4, S_WRA = 5,
                 S_PRE = 6, S_REF = 7, S_SACT = 8, S_SRD = 9, S_SWR = 10;

  logic clk = 0, rst_ni = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic [2:0] mcode = 0;
  logic [3:0] cmd_o;
  logic illegal_o;
  logic [1:0] power_o;
  logic [NB*4-1:0] bank_state_o;

  always #5 clk = ~clk;

  bank_cmd_tracker #(.NUM_BANKS(NB), .T_RP(TRP), .T_RC(TRC)) u_bank_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .a10_i(a10), .mode_code_i(mcode),
    .cmd_o(cmd_o), .illegal_o(illegal_o), .power_o(power_o),
    .bank_state_o(bank_state_o));

  int n_checks = 0, n_fail = 0;
  string cur_req = "R13";
  bit done = 0;

  // reference model
  int m_st[NB], m_cnt[NB];
  int m_ckeq, m_pow, m_code, m_cmd, m_ill;

  function automatic int blen(int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic model_step(int ck, int csn, int key, int b, int a, int code);
    int c; bit ok; bit allid, apb; int tgt; int ns[NB]; int nc[NB]; bit full, ser;
    if (!m_ckeq) c = NOP;
    else if (csn) c = DESEL;
    else case (key)
      7: c = NOP; 0: c = MODE; 1: c = ck ? REF : SREF; 3: c = ACT;
      5: c = a ? RDA : RD; 4: c = a ? WRA : WR; 2: c = a ? PREA : PRE;
      default: c = BST;
    endcase
    allid = 1; apb = 0;
    foreach (m_st[i]) begin
      if (m_st[i] != S_IDLE) allid = 0;
      if (m_st[i] == S_RDA || m_st[i] == S_WRA || m_st[i] == S_REF) apb = 1;
    end
    tgt = m_st[b];
    case (c)
      NOP, DESEL: ok = 1;
      MODE, REF, SREF: ok = allid;
      ACT: ok = (tgt == S_IDLE);
      RD, RDA, WR, WRA: ok = (tgt == S_ACT || tgt == S_RD || tgt == S_WR || tgt == S_SACT);
      PRE: ok = (tgt == S_IDLE || tgt == S_ACT || tgt == S_RD || tgt == S_WR || tgt == S_PRE);
      PREA: ok = !apb;
      default: ok = (tgt == S_RD || tgt == S_WR);
    endcase
    if (m_ckeq && !ck && allid && !(c == NOP || c == DESEL || c == SREF)) ok = 0;
    full = (m_code == 7); ser = (m_code == 6);
    foreach (m_st[i]) begin
      ns[i] = m_st[i]; nc[i] = m_cnt[i];
      if (m_ckeq) begin
        if ((m_st[i] == S_RD || m_st[i] == S_WR) && !full) begin
          if (m_cnt[i] == 1) ns[i] = S_ACT; else nc[i]--;
        end else if ((m_st[i] == S_RDA || m_st[i] == S_WRA) && !full) begin
          if (m_cnt[i] == 1) begin ns[i] = S_PRE; nc[i] = TRP; end else nc[i]--;
        end else if (m_st[i] == S_PRE || m_st[i] == S_REF) begin
          if (m_cnt[i] == 1) ns[i] = S_IDLE; else nc[i]--;
        end
      end
    end
    if (ok) begin
      case (c)
        ACT: ns[b] = ser ? S_SACT : S_ACT;
        RD, RDA, WR, WRA: begin
          if (tgt == S_SACT) ns[b] = (c == RD || c == RDA) ? S_SRD : S_SWR;
          else begin
            ns[b] = (c == RD) ? S_RD : (c == RDA) ? S_RDA : (c == WR) ? S_WR : S_WRA;
            nc[b] = blen(m_code);
          end
        end
        PRE: if (tgt == S_ACT || tgt == S_RD || tgt == S_WR) begin ns[b] = S_PRE; nc[b] = TRP; end
        PREA: foreach (m_st[i])
          if (m_st[i] inside {S_ACT, S_RD, S_WR, S_SACT, S_SRD, S_SWR}) begin
            ns[i] = S_PRE; nc[i] = TRP;
          end
        BST: ns[b] = S_ACT;
        REF: foreach (ns[i]) begin ns[i] = S_REF; nc[i] = TRC; end
        MODE: m_code = code;
        default: ;
      endcase
    end
    if (!m_ckeq && ck && m_pow == 2) foreach (ns[i]) begin ns[i] = S_REF; nc[i] = TRC; end
    if (m_ckeq) begin
      if (!ck) m_pow = !allid ? 3 : (c == SREF) ? 2 : 1;
      else m_pow = 0;
    end else if (ck) m_pow = 0;
    m_cmd = c; m_ill = !ok; m_ckeq = ck;
    foreach (m_st[i]) begin m_st[i] = ns[i]; m_cnt[i] = nc[i]; end
  endtask

  task automatic compare();
    logic [NB*4-1:0] eb;
    foreach (m_st[i]) eb[4*i +: 4] = m_st[i][3:0];
    n_checks++;
    if (cmd_o !== m_cmd[3:0] || illegal_o !== m_ill[0] || power_o !== m_pow[1:0] ||
        bank_state_o !== eb) begin
      n_fail++;
      $display("FAIL %s: cmd=%0d ill=%0d pow=%0d banks=%h expected cmd=%0d ill=%0d pow=%0d banks=%h",
               cur_req, cmd_o, illegal_o, power_o, bank_state_o, m_cmd, m_ill, m_pow, eb);
    end
  endtask

  task automatic cyc(int c, int b = 0, bit ck = 1, int code = 0);
    int key; bit csn; bit a;
    csn = 0; a = 0;
    case (c)
      DESEL: begin csn = 1; key = 3; end
      MODE: key = 0;
      REF, SREF: key = 1;
      ACT: key = 3;
      RD: key = 5; RDA: begin key = 5; a = 1; end
      WR: key = 4; WRA: begin key = 4; a = 1; end
      PRE: key = 2; PREA: begin key = 2; a = 1; end
      BST: key = 6;
      default: key = 7;
    endcase
    cke = ck; cs_n = csn; ras_n = key[2]; cas_n = key[1]; we_n = key[0];
    ba = b[1:0]; a10 = a; mcode = code[2:0];
    model_step(ck, csn, key, b, a, code);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    repeat (n) cyc(NOP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (m_st[i]) begin m_st[i] = 0; m_cnt[i] = 0; end
    m_ckeq = 1; m_pow = 0; m_code = 2; m_cmd = 0; m_ill = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    cur_req = "R13"; compare();

    cur_req = "R1"; cyc(DESEL, 1); cyc(NOP); idle(1);
    cur_req = "R2"; cyc(ACT, 0); cyc(ACT, 0);
    cur_req = "R3"; cyc(RD, 0); idle(5);
    cur_req = "R5"; cyc(PRE, 0); cyc(ACT, 0); idle(4); cyc(PRE, 2);
    cur_req = "R3"; cyc(MODE, 0, 1, 0); cyc(ACT, 1); cyc(WR, 1); idle(2);
    cur_req = "R6"; cyc(MODE, 0, 1, 3); cyc(REF);
    cur_req = "R5"; cyc(PREA); idle(4);
    cur_req = "R3"; cyc(MODE, 0, 1, 7); cyc(ACT, 2); cyc(WR, 2); idle(10);
    cur_req = "R7"; cyc(BST, 2); cyc(BST, 2); cyc(PREA); idle(4);
    cur_req = "R7"; cyc(MODE, 0, 1, 3); cyc(ACT, 3); cyc(RD, 3); idle(3); cyc(WR, 3); idle(10);
    cur_req = "R4"; cyc(RDA, 3); idle(2); cyc(RD, 3); cyc(PRE, 3); cyc(BST, 3);
    cyc(PREA); cyc(WR, 3); idle(10);
    cur_req = "R4"; cyc(ACT, 1); cyc(WRA, 1); idle(12);
    cur_req = "R5"; cyc(ACT, 0); cyc(ACT, 1); cyc(PRE, 0); cyc(ACT, 0); idle(1);
    cyc(PREA); idle(5);
    cur_req = "R6"; cyc(REF); cyc(ACT, 2); cyc(REF); idle(6); cyc(ACT, 2); cyc(REF);
    cyc(MODE, 0, 1, 1); cyc(PRE, 2); idle(4);
    cur_req = "R8"; cyc(MODE, 0, 1, 6); cyc(ACT, 1); cyc(PRE, 1); cyc(RD, 1); idle(12);
    cyc(RD, 1); cyc(BST, 1); cyc(ACT, 1); cyc(ACT, 2); cyc(WRA, 2); idle(3);
    cyc(PREA); idle(5);
    cur_req = "R9"; cyc(BST, 0); cyc(RD, 2); cyc(PRE, 3); idle(1);
    cur_req = "R11"; cyc(NOP, 0, 0); cyc(ACT, 0, 0); cyc(ACT, 1, 0); cyc(NOP, 0, 1); idle(1);
    cyc(ACT, 0, 0); cyc(NOP, 0, 0); cyc(NOP, 0, 1); idle(1);
    cur_req = "R10"; cyc(SREF, 0, 0); cyc(NOP, 0, 0); cyc(REF, 0, 0); idle(8);
    cur_req = "R12"; cyc(MODE, 0, 1, 3); cyc(ACT, 0); cyc(RD, 0, 0); cyc(NOP, 0, 0);
    cyc(BST, 0, 0); cyc(NOP, 0, 0); cyc(NOP, 0, 1); idle(10);
    cur_req = "R12"; cyc(WR, 0); idle(2); cyc(PREA, 0, 0); cyc(NOP, 0, 0); cyc(NOP, 0, 1); idle(5);
    cur_req = "R1"; cyc(DESEL, 2); cyc(ACT, 2); cyc(DESEL, 2); cyc(PREA); idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule